// File: doc/BRIEF.md
# Hash Tree Memory Integrity Walker

This block checks that a data block read back from untrusted external memory is genuine. External memory holds a binary hash tree. The data blocks are the leaves, and each internal node holds the hash of its left child followed by its right child. The tree is split into several independent subtrees. The root value of each subtree is a secret that is kept on chip, where an attacker cannot change it.

A request carries a leaf index and the data word to be checked. The walker starts at the leaf and climbs one level at a time. At each level it fetches the sibling node and, below the subtree root, the stored parent node. It then recomputes the parent and compares it with the stored value. At the subtree root it compares the result with the on-chip secret for that subtree, and the walk stops there; it never climbs above the subtree root. The first mismatch ends the walk with a fail pulse. A match with the secret ends it with a pass pulse.

The hash used is a small deterministic mixing function. It stands in for a cryptographic core, so a bench can build a reference tree from it.

Top module: `tree_verify`

## Requirements
- R1: While reset is held and after it is released, `busy_o`, `pass_o`, `fail_o` and `mem_req_o` are low until a request is accepted.
- R2: A parent value is `((L rotated left by 5) ^ R) + 0x9E3779B9` on 32-bit words. At level k the node on the path is the left child when bit k of the leaf index is 0, and the right child when that bit is 1.
- R3: At level k the walker reads the sibling at (level k, node (index>>k) XOR 1). Below the subtree root it also reads the stored parent at (level k+1, node index>>(k+1)). Leaves are level 0.
- R4: When every recomputed node matches, `pass_o` is high for exactly one cycle. A full walk makes 2*LEVELS-1 memory reads, where LEVELS = IDX_W - TREE_W (7 reads by default).
- R5: A recomputed node that differs from the stored parent gives a one-cycle `fail_o` and ends the walk at once, with no further memory reads.
- R6: The walk stops at the subtree root. It compares with the on-chip secret selected by the top TREE_W bits of the index and never requests a level at or above LEVELS.
- R7: A subtree whose secret has never been written since reset always fails at the root comparison.
- R8: `busy_o` is high from the cycle after a request is accepted until the result pulse. A request presented while busy is ignored and produces no result.
- R9: `pass_o` and `fail_o` are never high together, and each walk produces exactly one of them.
- R10: Writing a secret (`key_we_i`, `key_sel_i`, `key_val_i`) replaces that subtree's trusted root value only. Other subtrees are unaffected.
- R11: A memory request keeps its level and node stable until `mem_ack_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken when not busy |
| req_idx_i | input | IDX_W | Leaf index to check |
| req_data_i | input | DATA_W | Leaf data to check |
| busy_o | output | 1 | Walk in progress |
| key_we_i | input | 1 | Secret write enable |
| key_sel_i | input | TREE_W | Subtree selected for the secret write |
| key_val_i | input | DATA_W | Trusted root value to store |
| mem_req_o | output | 1 | Node read request |
| mem_lvl_o | output | LVL_W | Tree level of the requested node |
| mem_node_o | output | IDX_W | Node index within the level |
| mem_ack_i | input | 1 | Read data valid, ends the request |
| mem_rdata_i | input | DATA_W | Node value read |
| pass_o | output | 1 | One-cycle pulse: block verified |
| fail_o | output | 1 | One-cycle pulse: mismatch found |

## Verification
A wrong level counter or a wrong index shift shows up at the memory port in the first wrong request. The requested node is then neither the sibling nor the parent of the path, or its level reaches the subtree root. The bench checks the address of every read as it happens. A left/right swap or a corrupted running hash is only seen at the next comparison, which is one level later. There it turns a genuine block into a fail, or changes the number of reads counted for that walk. A stale secret or a bad secret-valid flag is seen only at the end of a full walk, as the wrong pass or fail result.

// File: rtl/tree_verify_pkg.sv
package tree_verify_pkg;
  localparam logic [31:0] HASH_K   = 32'h9E37_79B9;
  localparam int unsigned HASH_ROT = 5;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SIB,
    ST_PAR,
    ST_CMP
  } walk_st_e;
endpackage

// File: rtl/tv_mix.sv
module tv_mix
  import tree_verify_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] left_i,
  input  logic [DATA_W-1:0] right_i,
  output logic [DATA_W-1:0] hash_o
);
  localparam int unsigned ROT = HASH_ROT % DATA_W;

  logic [DATA_W-1:0] rot_l;

  generate
    if (ROT == 0) begin : g_norot
      assign rot_l = left_i;
    end else begin : g_rot
      assign rot_l = {left_i[DATA_W-ROT-1:0], left_i[DATA_W-1:DATA_W-ROT]};
    end
  endgenerate

  assign hash_o = (rot_l ^ right_i) + DATA_W'(HASH_K);
endmodule

// File: rtl/tv_key_store.sv
module tv_key_store #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TREE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [TREE_W-1:0] wsel_i,
  input  logic [DATA_W-1:0] wval_i,
  input  logic [TREE_W-1:0] rsel_i,
  output logic [DATA_W-1:0] rval_o,
  output logic              rok_o
);
  localparam int unsigned NUM_TREES = 1 << TREE_W;

  logic [DATA_W-1:0]    val_q [NUM_TREES];
  logic [NUM_TREES-1:0] ok_q;

  generate
    for (genvar t = 0; t < NUM_TREES; t++) begin : g_slot
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          val_q[t] <= '0;
          ok_q[t]  <= 1'b0;
        end else if (we_i && (wsel_i == TREE_W'(t))) begin
          val_q[t] <= wval_i;
          ok_q[t]  <= 1'b1;
        end
      end
    end
  endgenerate

  assign rval_o = val_q[rsel_i];
  assign rok_o  = ok_q[rsel_i];
endmodule

// File: rtl/tv_walker.sv
module tv_walker
  import tree_verify_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned TREE_W = 4,
  parameter int unsigned LVL_W  = $clog2(IDX_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [IDX_W-1:0]  req_idx_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic [LVL_W-1:0]  mem_lvl_o,
  output logic [IDX_W-1:0]  mem_node_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [TREE_W-1:0] key_sel_o,
  input  logic [DATA_W-1:0] key_val_i,
  input  logic              key_ok_i,
  output logic              pass_o,
  output logic              fail_o
);
  localparam int unsigned LEVELS = IDX_W - TREE_W;

  walk_st_e          state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] cur_q, sib_q, par_q;
  logic [LVL_W-1:0]  lvl_q;
  logic              pass_q, fail_q;

  logic [LVL_W-1:0]  lvl_nxt;
  logic              at_top;
  logic [IDX_W-1:0]  idx_sh, sib_node, par_node;
  logic [DATA_W-1:0] left, right, hash;
  logic              node_ok;

  assign lvl_nxt  = lvl_q + LVL_W'(1);
  assign at_top   = (lvl_nxt == LVL_W'(LEVELS));
  assign idx_sh   = idx_q >> lvl_q;
  assign sib_node = idx_sh ^ IDX_W'(1);
  assign par_node = idx_q >> lvl_nxt;

  // path bit 0 => running node is the left child
  assign left  = idx_sh[0] ? sib_q : cur_q;
  assign right = idx_sh[0] ? cur_q : sib_q;

  tv_mix #(.DATA_W(DATA_W)) i_mix (
    .left_i (left),
    .right_i(right),
    .hash_o (hash)
  );

  assign key_sel_o = idx_q[IDX_W-1 -: TREE_W];
  assign node_ok   = at_top ? (key_ok_i && (hash == key_val_i)) : (hash == par_q);

  always_comb begin
    mem_req_o  = 1'b0;
    mem_lvl_o  = '0;
    mem_node_o = '0;
    unique case (state_q)
      ST_SIB: begin
        mem_req_o  = 1'b1;
        mem_lvl_o  = lvl_q;
        mem_node_o = sib_node;
      end
      ST_PAR: begin
        mem_req_o  = 1'b1;
        mem_lvl_o  = lvl_nxt;
        mem_node_o = par_node;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cur_q   <= '0;
      sib_q   <= '0;
      par_q   <= '0;
      lvl_q   <= '0;
      pass_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      pass_q <= 1'b0;
      fail_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            idx_q   <= req_idx_i;
            cur_q   <= req_data_i;
            lvl_q   <= '0;
            state_q <= ST_SIB;
          end
        end
        ST_SIB: begin
          if (mem_ack_i) begin
            sib_q   <= mem_rdata_i;
            state_q <= at_top ? ST_CMP : ST_PAR;
          end
        end
        ST_PAR: begin
          if (mem_ack_i) begin
            par_q   <= mem_rdata_i;
            state_q <= ST_CMP;
          end
        end
        ST_CMP: begin
          if (!node_ok) begin
            fail_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (at_top) begin
            pass_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            cur_q   <= hash;
            lvl_q   <= lvl_nxt;
            state_q <= ST_SIB;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign pass_o = pass_q;
  assign fail_o = fail_q;
endmodule

// File: rtl/tree_verify.sv
module tree_verify #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned TREE_W = 4,
  parameter int unsigned LVL_W  = $clog2(IDX_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [IDX_W-1:0]  req_idx_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic              busy_o,
  input  logic              key_we_i,
  input  logic [TREE_W-1:0] key_sel_i,
  input  logic [DATA_W-1:0] key_val_i,
  output logic              mem_req_o,
  output logic [LVL_W-1:0]  mem_lvl_o,
  output logic [IDX_W-1:0]  mem_node_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              pass_o,
  output logic              fail_o
);
  logic [TREE_W-1:0] rd_sel;
  logic [DATA_W-1:0] rd_val;
  logic              rd_ok;

  tv_key_store #(.DATA_W(DATA_W), .TREE_W(TREE_W)) i_store (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (key_we_i),
    .wsel_i(key_sel_i),
    .wval_i(key_val_i),
    .rsel_i(rd_sel),
    .rval_o(rd_val),
    .rok_o (rd_ok)
  );

  tv_walker #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .TREE_W(TREE_W), .LVL_W(LVL_W)
  ) i_walker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_idx_i  (req_idx_i),
    .req_data_i (req_data_i),
    .busy_o     (busy_o),
    .mem_req_o  (mem_req_o),
    .mem_lvl_o  (mem_lvl_o),
    .mem_node_o (mem_node_o),
    .mem_ack_i  (mem_ack_i),
    .mem_rdata_i(mem_rdata_i),
    .key_sel_o  (rd_sel),
    .key_val_i  (rd_val),
    .key_ok_i   (rd_ok),
    .pass_o     (pass_o),
    .fail_o     (fail_o)
  );
endmodule

// File: rtl/tv_sva.sv
module tv_sva #(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned TREE_W = 4,
  parameter int unsigned LVL_W  = $clog2(IDX_W + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [IDX_W-1:0] req_idx_i,
  input logic             busy_o,
  input logic             mem_req_o,
  input logic [LVL_W-1:0] mem_lvl_o,
  input logic [IDX_W-1:0] mem_node_o,
  input logic             mem_ack_i,
  input logic             pass_o,
  input logic             fail_o
);
  localparam int unsigned LEVELS = IDX_W - TREE_W;

  logic [IDX_W-1:0] idx_cap;
  logic [IDX_W-1:0] path_node;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_cap <= '0;
    else if (req_valid_i && !busy_o) idx_cap <= req_idx_i;
  end

  assign path_node = idx_cap >> mem_lvl_o;

  assert_single_result_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pass_o && fail_o));

  assert_pass_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |=> !pass_o);

  assert_fail_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> !fail_o && !mem_req_o);

  assert_addr_path_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_node_o == path_node) || (mem_node_o == (path_node ^ IDX_W'(1))));

  assert_level_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_lvl_o < LVL_W'(LEVELS)));

  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);

  assert_busy_ends_with_result_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (pass_o || fail_o));

  assert_req_stable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> mem_req_o && $stable(mem_lvl_o) && $stable(mem_node_o));
endmodule

bind tree_verify tv_sva #(.IDX_W(IDX_W), .TREE_W(TREE_W), .LVL_W(LVL_W)) i_tv_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_idx_i  (req_idx_i),
  .busy_o     (busy_o),
  .mem_req_o  (mem_req_o),
  .mem_lvl_o  (mem_lvl_o),
  .mem_node_o (mem_node_o),
  .mem_ack_i  (mem_ack_i),
  .pass_o     (pass_o),
  .fail_o     (fail_o)
);

// File: tb/test_tree_verify.sv
module test_tree_verify;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W  = 8;
  localparam int TREE_W = 4;
  localparam int LVL_W  = 4;
  localparam int LEVELS = IDX_W - TREE_W;
  localparam int NLEAF  = 1 << IDX_W;
  localparam int NTREE  = 1 << TREE_W;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic [IDX_W-1:0]  req_idx_i = '0;
  logic [31:0]       req_data_i = '0;
  logic              busy_o;
  logic              key_we_i = 1'b0;
  logic [TREE_W-1:0] key_sel_i = '0;
  logic [31:0]       key_val_i = '0;
  logic              mem_req_o;
  logic [LVL_W-1:0]  mem_lvl_o;
  logic [IDX_W-1:0]  mem_node_o;
  logic              mem_ack_i = 1'b0;
  logic [31:0]       mem_rdata_i = '0;
  logic              pass_o, fail_o;

  tree_verify #(.DATA_W(32), .IDX_W(IDX_W), .TREE_W(TREE_W), .LVL_W(LVL_W)) i_tree_verify (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_idx_i(req_idx_i), .req_data_i(req_data_i),
    .busy_o(busy_o),
    .key_we_i(key_we_i), .key_sel_i(key_sel_i), .key_val_i(key_val_i),
    .mem_req_o(mem_req_o), .mem_lvl_o(mem_lvl_o), .mem_node_o(mem_node_o),
    .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
    .pass_o(pass_o), .fail_o(fail_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_checks = 0;
  int n_fails  = 0;
  int pushed   = 0;
  int seen     = 0;
  int reads    = 0;
  bit finished = 1'b0;
  logic [IDX_W-1:0] cur_idx = '0;

  logic [31:0] tmem [LEVELS][NLEAF];
  logic [31:0] sec_val [NTREE];
  bit          sec_set [NTREE];

  bit    exp_pass_q [$];
  int    exp_reads_q [$];
  string exp_tag_q [$];

  // R2: parent = (rotl5(L) ^ R) + 0x9E3779B9
  function automatic logic [31:0] ref_mix(input logic [31:0] l, input logic [31:0] r);
    return ({l[26:0], l[31:27]} ^ r) + 32'h9E37_79B9;
  endfunction

  function automatic logic [31:0] leaf_val(input int i);
    return 32'hA5C3_0000 ^ (i * 32'h0101_0103) ^ (i << 20);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void build_tree();
    for (int i = 0; i < NLEAF; i++) tmem[0][i] = leaf_val(i);
    for (int k = 1; k < LEVELS; k++)
      for (int j = 0; j < (NLEAF >> k); j++)
        tmem[k][j] = ref_mix(tmem[k-1][2*j], tmem[k-1][2*j+1]);
  endfunction

  function automatic logic [31:0] tree_root(input int t);
    return ref_mix(tmem[LEVELS-1][2*t], tmem[LEVELS-1][2*t+1]);
  endfunction

  function automatic void model(input logic [IDX_W-1:0] idx, input logic [31:0] d,
                                output bit ok, output int rd);
    logic [31:0] cur, sib, h;
    int node;
    bit done;
    cur = d; rd = 0; ok = 1'b0; done = 1'b0;
    for (int k = 0; k < LEVELS; k++) begin
      if (!done) begin
        node = int'(idx) >> k;
        sib = tmem[k][node ^ 1];
        rd++;
        h = node[0] ? ref_mix(sib, cur) : ref_mix(cur, sib);
        if (k + 1 < LEVELS) begin
          rd++;
          if (h != tmem[k+1][node >> 1]) done = 1'b1;
          cur = h;
        end else begin
          ok = sec_set[int'(idx) >> LEVELS] && (h == sec_val[int'(idx) >> LEVELS]);
          done = 1'b1;
        end
      end
    end
  endfunction

  task automatic load_key(input int t, input logic [31:0] v);
    @(negedge clk_i);
    key_we_i = 1'b1; key_sel_i = TREE_W'(t); key_val_i = v;
    @(negedge clk_i);
    key_we_i = 1'b0;
    sec_val[t] = v; sec_set[t] = 1'b1;
  endtask

  task automatic issue(input logic [IDX_W-1:0] idx, input logic [31:0] d, input string tag,
                       input bit poke_busy);
    bit ok; int rd;
    model(idx, d, ok, rd);
    exp_pass_q.push_back(ok);
    exp_reads_q.push_back(rd);
    exp_tag_q.push_back(tag);
    pushed++;
    @(negedge clk_i);
    while (busy_o) @(negedge clk_i);
    cur_idx = idx;
    req_valid_i = 1'b1; req_idx_i = idx; req_data_i = d;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    if (poke_busy) begin
      // R8: request while busy must be dropped
      @(negedge clk_i);
      req_valid_i = 1'b1; req_idx_i = idx ^ 8'h11; req_data_i = ~d;
      repeat (2) @(negedge clk_i);
      req_valid_i = 1'b0;
    end
    while (seen < pushed) @(negedge clk_i);
    if (poke_busy) begin
      repeat (4) @(negedge clk_i);
      check(!busy_o && seen == pushed, "R8 busy request ignored", int'(busy_o), 0);
    end
  endtask

  // scoreboard monitor and memory model
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni) begin
        if (pass_o || fail_o) begin
          seen++;
          if (exp_pass_q.size() == 0) begin
            check(1'b0, "R8 unexpected result", int'(pass_o), 0);
          end else begin
            bit e_ok; int e_rd; string tg;
            e_ok = exp_pass_q.pop_front();
            e_rd = exp_reads_q.pop_front();
            tg   = exp_tag_q.pop_front();
            check(!(pass_o && fail_o), {tg, " R9 exclusive"}, int'(fail_o), 0);
            check(pass_o == e_ok, {tg, " result"}, int'(pass_o), int'(e_ok));
            check(reads == e_rd, {tg, " read count"}, reads, e_rd);
          end
          reads = 0;
        end
        if (mem_ack_i) begin
          mem_ack_i = 1'b0;
        end else if (mem_req_o) begin
          int lv, nd, pn;
          lv = int'(mem_lvl_o); nd = int'(mem_node_o);
          pn = int'(cur_idx) >> lv;
          check((nd == pn || nd == (pn ^ 1)) && lv < LEVELS, "R3 R6 read address", nd, pn);
          mem_rdata_i = (lv < LEVELS) ? tmem[lv][nd] : 32'h0;
          mem_ack_i = 1'b1;
          reads++;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", seen, pushed);
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    build_tree();
    for (int t = 0; t < NTREE; t++) begin sec_set[t] = 1'b0; sec_val[t] = '0; end
    repeat (3) @(negedge clk_i);
    check(!busy_o && !pass_o && !fail_o && !mem_req_o, "R1 in reset", int'(busy_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(!busy_o && !pass_o && !fail_o && !mem_req_o, "R1 after reset", int'(mem_req_o), 0);

    // tree 15 deliberately left without a secret
    for (int t = 0; t < NTREE - 1; t++) load_key(t, tree_root(t));

    // R2 R4: genuine blocks on several paths
    issue(8'h00, leaf_val(8'h00), "R4 idx00", 1'b0);
    issue(8'hEF, leaf_val(8'hEF), "R4 idxEF", 1'b0);
    issue(8'h5A, leaf_val(8'h5A), "R2 idx5A", 1'b0);
    issue(8'h81, leaf_val(8'h81), "R2 idx81", 1'b0);
    issue(8'h37, leaf_val(8'h37), "R4 idx37", 1'b0);

    // R5: wrong data, tampered sibling, tampered mid node
    issue(8'h22, leaf_val(8'h22) ^ 32'h1, "R5 bad data", 1'b0);
    tmem[0][8'h45 ^ 1] ^= 32'h8000_0000;
    issue(8'h45, leaf_val(8'h45), "R5 bad sibling", 1'b0);
    build_tree();
    tmem[2][8'h6C >> 2] ^= 32'h0000_0100;
    issue(8'h6C, leaf_val(8'h6C), "R5 bad mid node", 1'b0);
    build_tree();

    // R6: fully consistent forgery below the root is caught by the secret
    tmem[0][8'h93] = 32'hDEAD_BEEF;
    for (int k = 1; k < LEVELS; k++) begin
      int j; j = 8'h93 >> k;
      tmem[k][j] = ref_mix(tmem[k-1][2*j], tmem[k-1][2*j+1]);
    end
    issue(8'h93, 32'hDEAD_BEEF, "R6 forged subtree", 1'b0);
    build_tree();
    issue(8'h93, leaf_val(8'h93), "R6 restored", 1'b0);

    // R7: subtree without secret
    issue(8'hF3, leaf_val(8'hF3), "R7 no secret", 1'b0);
    load_key(15, tree_root(15));
    issue(8'hF3, leaf_val(8'hF3), "R7 secret loaded", 1'b0);

    // R10: secret rewrite affects only its own subtree
    load_key(2, tree_root(2) ^ 32'h4);
    issue(8'h2B, leaf_val(8'h2B), "R10 wrong secret", 1'b0);
    issue(8'h3B, leaf_val(8'h3B), "R10 other tree", 1'b0);
    load_key(2, tree_root(2));
    issue(8'h2B, leaf_val(8'h2B), "R10 secret restored", 1'b0);

    // R8: requests while busy
    issue(8'h77, leaf_val(8'h77), "R8 busy pass", 1'b1);
    issue(8'h78, leaf_val(8'h78) ^ 32'h2, "R8 busy fail", 1'b1);

    repeat (5) @(negedge clk_i);
    check(exp_pass_q.size() == 0, "R9 all results seen", exp_pass_q.size(), 0);
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule